// File: doc/BRIEF.md
# Emergency Output Override

This block sits between a PWM generator and the output pins of a power stage. An external emergency line goes into it. When that line makes its active transition, the block sets a sticky flag with no software involved. While the flag is set, every output whose enable bit is set shows its programmed safe level instead of its normal PWM value. Outputs whose enable bit is clear keep passing their normal value.

A polarity select chooses which transition counts as active: falling for an active-low line, rising for an active-high line. A path select picks one of two routes for the line. The synchronized route passes it through a two-flop synchronizer before edge detection. The direct route samples it in a single register, which gives the shortest reaction. Only a transition arms the flag; a steady level never does. The flag stays set until a clear strobe removes it. An active transition in the same cycle as a clear keeps the flag set.

Top module: `emg_override`

## Requirements
- R1: After reset `emg_flag` is 0 and every `pin_out[i]` equals `norm_out[i]`.
- R2: With `pol_sel`=1 a high-to-low transition of `emg_in` is active. With `pol_sel`=0 a low-to-high transition is active.
- R3: The transition opposite to the active one never sets `emg_flag`.
- R4: With `path_sel`=0 (direct), an active transition made between two clock edges sets `emg_flag` at the first following edge.
- R5: With `path_sel`=1 (synchronized), an active transition sets `emg_flag` at the third following edge. `emg_flag` stays 0 after the first and second edges.
- R6: While `emg_flag` is 1, `pin_out[i]` equals `safe_lvl[i]` when `en_mask[i]`=1 and equals `norm_out[i]` when `en_mask[i]`=0. While `emg_flag` is 0, `pin_out` equals `norm_out`. This is combinational from the current mask, level and normal inputs.
- R7: Once set, `emg_flag` stays 1 when `emg_in` returns to its inactive level.
- R8: A one-cycle `flag_clr` pulse clears `emg_flag` at the next edge. If an active transition is detected at that same edge, `emg_flag` stays 1.
- R9: An `emg_in` held at its active level from reset onwards is not a transition and does not set `emg_flag`.
- R10: After a clear, an `emg_in` held steadily at its active level does not set `emg_flag` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| emg_in | input | 1 | Raw emergency line |
| pol_sel | input | 1 | 1: active low (falling transition); 0: active high (rising transition) |
| path_sel | input | 1 | 1: synchronized path; 0: direct path |
| en_mask | input | N_OUT | Per-output override enable |
| safe_lvl | input | N_OUT | Per-output level driven during an emergency |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| norm_out | input | N_OUT | Normal output values from the PWM generator |
| pin_out | output | N_OUT | Final output pin values |
| emg_flag | output | 1 | Sticky emergency flag |

## Verification
The bench builds the block with N_OUT=4. At that width every combination of enable mask and safe level can be swept against several normal patterns, in both the flagged and the idle state. All four combinations of polarity and path are run with the same sequence:
- a level already present at reset
- the opposite transition
- the active transition, with its exact latency
- holding after the line returns
- clearing with the line held active
- a clear coinciding with a new detection

With the narrow width, each of these orderings fits in a short run.

// File: rtl/emg_pkg.sv
package emg_pkg;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic prev;
        logic primed;
    } edge_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;
endpackage

// File: rtl/emg_sync.sv
module emg_sync #(
    parameter int STAGES = emg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_vld
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic [STAGES-1:0] vld;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], d};
        s_d.vld   = {s_q.vld[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q     = s_q.chain[STAGES-1];
    assign q_vld = s_q.vld[STAGES-1];
endmodule

// File: rtl/emg_edge.sv
module emg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic d_vld,
    input  logic pol_low,
    output logic hit
);
    import emg_pkg::*;

    edge_st_t e_d, e_q;
    logic     act_now, act_prev;

    always_comb begin
        act_now  = d ^ pol_low;
        act_prev = e_q.prev ^ pol_low;
        hit      = e_q.primed & d_vld & act_now & ~act_prev;
        e_d      = e_q;
        if (d_vld) begin
            e_d.prev   = d;
            e_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end
endmodule

// File: rtl/emg_flag_ctl.sv
module emg_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    import emg_pkg::*;

    flag_st_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (set)      f_d.flag = 1'b1;
        else if (clr) f_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flag = f_q.flag;
endmodule

// File: rtl/emg_pin_mux.sv
module emg_pin_mux #(
    parameter int N_OUT = 8
) (
    input  logic             flag,
    input  logic [N_OUT-1:0] en_mask,
    input  logic [N_OUT-1:0] safe_lvl,
    input  logic [N_OUT-1:0] norm_out,
    output logic [N_OUT-1:0] pin_out
);
    for (genvar i = 0; i < N_OUT; i++) begin : g_pin
        logic take_safe;
        always_comb begin
            take_safe  = flag & en_mask[i];
            pin_out[i] = take_safe ? safe_lvl[i] : norm_out[i];
        end
    end
endmodule

// File: rtl/emg_override.sv
module emg_override #(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emg_in,
    input  logic             pol_sel,
    input  logic             path_sel,
    input  logic [N_OUT-1:0] en_mask,
    input  logic [N_OUT-1:0] safe_lvl,
    input  logic             flag_clr,
    input  logic [N_OUT-1:0] norm_out,
    output logic [N_OUT-1:0] pin_out,
    output logic             emg_flag
);
    logic sync_q, sync_vld;
    logic hit_dir, hit_sync, hit_sel;

    emg_sync #(.STAGES(emg_pkg::SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(emg_in), .q(sync_q), .q_vld(sync_vld)
    );

    emg_edge u_edge_dir (
        .clk(clk), .rst_n(rst_n), .d(emg_in), .d_vld(1'b1),
        .pol_low(pol_sel), .hit(hit_dir)
    );

    emg_edge u_edge_sync (
        .clk(clk), .rst_n(rst_n), .d(sync_q), .d_vld(sync_vld),
        .pol_low(pol_sel), .hit(hit_sync)
    );

    assign hit_sel = path_sel ? hit_sync : hit_dir;

    emg_flag_ctl u_flag (
        .clk(clk), .rst_n(rst_n), .set(hit_sel), .clr(flag_clr), .flag(emg_flag)
    );

    emg_pin_mux #(.N_OUT(N_OUT)) u_mux (
        .flag(emg_flag), .en_mask(en_mask), .safe_lvl(safe_lvl),
        .norm_out(norm_out), .pin_out(pin_out)
    );
endmodule

// File: rtl/emg_override_chk.sv
module emg_override_chk #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             emg_in,
    input logic             pol_sel,
    input logic             path_sel,
    input logic [N_OUT-1:0] en_mask,
    input logic [N_OUT-1:0] safe_lvl,
    input logic             flag_clr,
    input logic [N_OUT-1:0] norm_out,
    input logic [N_OUT-1:0] pin_out,
    input logic             emg_flag
);
    logic [2:0] cyc_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
    end
    assign ready = (cyc_q >= 3'd5);

    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !emg_flag |-> (pin_out == norm_out));

    // R6
    unmasked_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~en_mask) == (norm_out & ~en_mask)));

    // R8
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $fell(emg_flag)) |-> $past(flag_clr));

    // R4
    direct_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $rose(emg_flag) && !$past(path_sel)) |->
        ((($past(emg_in) ^ $past(pol_sel)) == 1'b1) &&
         (($past(emg_in, 2) ^ $past(pol_sel)) == 1'b0)));

    // R5
    sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cyc_q == 3'd7 && $rose(emg_flag) && $past(path_sel)) |->
        ((($past(emg_in, 3) ^ $past(pol_sel)) == 1'b1) &&
         (($past(emg_in, 4) ^ $past(pol_sel)) == 1'b0)));

    logic unused_ok;
    assign unused_ok = ^safe_lvl;
endmodule

bind emg_override emg_override_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .emg_in(emg_in), .pol_sel(pol_sel),
    .path_sel(path_sel), .en_mask(en_mask), .safe_lvl(safe_lvl),
    .flag_clr(flag_clr), .norm_out(norm_out), .pin_out(pin_out),
    .emg_flag(emg_flag)
);

// File: tb/sim_emg_override.sv
`timescale 1ns/1ps
module sim_emg_override;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         emg_in = 1'b0;
    logic         pol_sel = 1'b0;
    logic         path_sel = 1'b0;
    logic [N-1:0] en_mask = '0;
    logic [N-1:0] safe_lvl = '0;
    logic         flag_clr = 1'b0;
    logic [N-1:0] norm_out = '0;
    logic [N-1:0] pin_out;
    logic         emg_flag;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    emg_override #(.N_OUT(N)) u0 (
        .clk(clk), .rst_n(rst_n), .emg_in(emg_in), .pol_sel(pol_sel),
        .path_sel(path_sel), .en_mask(en_mask), .safe_lvl(safe_lvl),
        .flag_clr(flag_clr), .norm_out(norm_out), .pin_out(pin_out),
        .emg_flag(emg_flag)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s pol=%0b path=%0b actual=%b expected=%b t=%0t",
                     req, pol_sel, path_sel, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic lvl);
        rst_n = 1'b0;
        emg_in = lvl;
        flag_clr = 1'b0;
        edges(3);
        rst_n = 1'b1;
        edges(6);
    endtask

    // Drive a level; expect the flag to rise exactly at edge lat (or never).
    task automatic drive_expect(input logic lvl, input int lat, input logic rises, input string req);
        emg_in = lvl;
        #1;
        for (int i = 1; i <= lat; i++) begin
            edges(1);
            if (i < lat) chk(req, {{(N-1){1'b0}}, emg_flag}, '0);
        end
        chk(req, {{(N-1){1'b0}}, emg_flag}, {{(N-1){1'b0}}, rises});
    endtask

    task automatic clr_pulse;
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        #150000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int cfg = 0; cfg < 4; cfg++) begin
            logic pl, ac, ia;
            int   lat;
            pl = cfg[0];
            pol_sel = pl;
            path_sel = cfg[1];
            lat = path_sel ? 3 : 1;
            ac = ~pl;
            ia = pl;
            norm_out = 4'b1010;
            en_mask = 4'b1111;
            safe_lvl = 4'b0000;

            // R1 reset state with inactive input
            do_reset(ia);
            chk("R1", {{(N-1){1'b0}}, emg_flag}, '0);
            chk("R1", pin_out, norm_out);

            // R9 active level held from reset
            do_reset(ac);
            edges(4);
            chk("R9", {{(N-1){1'b0}}, emg_flag}, '0);

            // R3 opposite transition
            drive_expect(ia, lat + 2, 1'b0, "R3");

            // R2 R4 R5 active transition with exact latency
            drive_expect(ac, lat, 1'b1, path_sel ? "R5" : "R4");
            chk("R2", {{(N-1){1'b0}}, emg_flag}, 4'b0001);
            chk("R6", pin_out, 4'b0000);

            // R7 hold after return to inactive
            emg_in = ia;
            edges(lat + 3);
            chk("R7", {{(N-1){1'b0}}, emg_flag}, 4'b0001);

            // R8 clear
            clr_pulse();
            chk("R8", {{(N-1){1'b0}}, emg_flag}, '0);
            chk("R1", pin_out, norm_out);

            // R10 clear with input held active
            drive_expect(ac, lat, 1'b1, "R2");
            clr_pulse();
            chk("R8", {{(N-1){1'b0}}, emg_flag}, '0);
            edges(6);
            chk("R10", {{(N-1){1'b0}}, emg_flag}, '0);

            // R8 set wins over coinciding clear
            drive_expect(ia, lat + 1, 1'b0, "R3");
            drive_expect(ac, lat, 1'b1, "R2");
            emg_in = ia;
            edges(lat + 1);
            emg_in = ac;
            if (lat > 1) edges(lat - 1);
            flag_clr = 1'b1;
            edges(1);
            flag_clr = 1'b0;
            chk("R8", {{(N-1){1'b0}}, emg_flag}, 4'b0001);

            // R6 full sweep while flagged
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int nv = 0; nv < 4; nv++) begin
                        logic [N-1:0] ev, sv, nn;
                        ev = e[N-1:0];
                        sv = s[N-1:0];
                        nn = N'(nv * 5);
                        en_mask = ev;
                        safe_lvl = sv;
                        norm_out = nn;
                        #1;
                        chk("R6", pin_out, (sv & ev) | (nn & ~ev));
                    end
                end
            end

            // R6 idle sweep after clear
            clr_pulse();
            for (int e = 0; e < 16; e++) begin
                en_mask = e[N-1:0];
                safe_lvl = ~e[N-1:0];
                norm_out = 4'b0110;
                #1;
                chk("R6", pin_out, 4'b0110);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule